// File: doc/BRIEF.md
# Fractional-Rate Nanosecond Timestamp Counter

This block keeps a free-running 64-bit time value that reads directly in nanoseconds. It runs from a reference clock. A phase accumulator issues time ticks at a programmable fraction of the reference rate, and every tick adds 32 to the time value. The five lowest time bits therefore never change from zero. With the ratio set so that ticks arrive at 31.25 MHz, the value counts nanoseconds.

The tick rate is the reference rate, times a source factor (x1 to x4), times a 16-bit multiplier, divided by a 16-bit divisor. The programmed ratio must not exceed one.

Software reaches the block through a single-cycle read/write port. Through it, software can:
- program the ratio;
- read or set the two 32-bit time words;
- arm an alarm on the low word;
- handle one interrupt through a status register and an enable register.

Reading the low word captures the high word. This lets a 64-bit value be assembled from two 32-bit reads.

Top module: `ns_timestamp_counter`

## Requirements
- R1: A clock edge with `rst_n` low sets the following: time 0, accumulator 0, divisor 8, multiplier 3, source 0, alarm 0, enable 0, status 0 and shadow 0.
- R2: On each reference cycle with a nonzero multiplier and a nonzero divisor, the value multiplier x factor is added to the accumulator. When the sum is at least the divisor, the divisor is subtracted and one tick is issued. At most one tick is issued per cycle.
- R3: Each tick adds 32 to the 64-bit time value, with a carry from the low word into the high word. Bits [4:0] of the time always read zero.
- R4: The source register bits [1:0] select the factor: 0 gives x1, 1 gives x2, 2 gives x3 and 3 gives x4.
- R5: When the multiplier or the divisor is zero, no tick is issued, and both the time and the accumulator hold.
- R6: The divisor and the multiplier keep only write-data bits [15:0]. Bits above that are ignored and read back as zero.
- R7: Writing the time words:
  - A write to time-low stores wdata with bits [4:0] forced to zero.
  - A write to time-high stores wdata.
  - In a cycle that writes either time word, no tick is applied.
- R8: Reading time-low copies the current high word into a shadow register. A read of time-high returns that shadow, not the live high word.
- R9: Status bit 0 is set when a tick moves the low word to a new value such that (alarm - old low) mod 2^32 lies between 1 and 32. If a set and a clear fall in the same cycle, the set wins.
- R10: A write to the status register clears each status bit whose wdata bit is 1, so writing all ones clears every pending interrupt.
- R11: `irq` equals status bit 0 AND enable bit 0. Writing zero to the enable register masks the interrupt.
- R12: The register offsets, as byte addresses, are:

  | Offset | Register |
  |---|---|
  | 0x100 | status |
  | 0x140 | enable |
  | 0x200 | divisor |
  | 0x210 | multiplier |
  | 0x220 | source |
  | 0x400 | time-low |
  | 0x410 | time-high |
  | 0x420 | alarm |

  `rdata` is combinational and valid while `rd_en` is high. It is zero for unmapped offsets and zero while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, same cycle as rd_en |
| irq | output | 1 | Interrupt request |

## Verification
A behavioural model in the bench follows the accumulator, the time, the shadow and the status cycle by cycle. The bench compares every read and the interrupt line on every clock.

The tests cover several ratios, including a ratio of exactly one and ratios that use each source factor. A design that tested the wrong edge (> instead of >=) would drift against the model. A design that ignored the factor would drift at x2 and x4.

The low word is forced to wrap, which catches a missing carry into the high word. Between a low read and a high read the bench lets the high word advance; a design without the shadow would return the live value.

The alarm is placed both just past a normal step and across the 32-bit wrap. A plain comparison would miss the wrap case. The bench also checks that clearing the status removes the interrupt, and that enable zero masks it.

// File: rtl/ts_pkg.sv
// Package: shared constants, register offsets and the ratio configuration
// type for the nanosecond timestamp counter.
package ts_pkg;
    localparam int RATIO_W = 16;
    localparam int WORD_W  = 32;

    localparam logic [11:0] OFF_ISTAT = 12'h100;
    localparam logic [11:0] OFF_IEN   = 12'h140;
    localparam logic [11:0] OFF_DIV   = 12'h200;
    localparam logic [11:0] OFF_MUL   = 12'h210;
    localparam logic [11:0] OFF_SRC   = 12'h220;
    localparam logic [11:0] OFF_TLO   = 12'h400;
    localparam logic [11:0] OFF_THI   = 12'h410;
    localparam logic [11:0] OFF_ALARM = 12'h420;

    typedef struct packed {
        logic [RATIO_W-1:0] div;
        logic [RATIO_W-1:0] mul;
        logic [1:0]         src;
    } ratio_cfg_t;

    // Source encoding n selects a pre-multiplication of n+1.
    function automatic logic [2:0] src_factor(input logic [1:0] s);
        return {1'b0, s} + 3'd1;
    endfunction
endpackage

// File: rtl/ts_rate_gen.sv
// Rate generator: a phase accumulator that issues one tick whenever the
// accumulated value mul*factor reaches div.
// Assumes the programmed ratio mul*factor/div is at most one; above that,
// ticks are still limited to one per cycle and the accumulator grows.
module ts_rate_gen
    import ts_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ratio_cfg_t cfg,
    input  logic       freeze,
    output logic       tick
);
    localparam int ACC_W = RATIO_W + 3;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] inc;
    logic [ACC_W-1:0] sum;
    logic             run;

    // Increment, running sum and tick decision for this cycle.
    always_comb begin
        run  = (cfg.mul != '0) && (cfg.div != '0);
        inc  = ACC_W'(cfg.mul) * ACC_W'(src_factor(cfg.src));
        sum  = acc_q + inc;
        tick = run && !freeze && (sum >= ACC_W'(cfg.div));
    end

    // Accumulator update; it holds when the ratio is zeroed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (run)
            acc_q <= (sum >= ACC_W'(cfg.div)) ? sum - ACC_W'(cfg.div) : sum;
    end

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mul == '0 || cfg.div == '0) |=> $stable(acc_q));
endmodule

// File: rtl/ts_time_core.sv
// Time core: the 64-bit time value that advances by 32 per tick, accepts
// software word writes, and flags the tick that crosses the alarm.
// Assumes a time-word write and a tick never both apply (the tick is frozen).
module ts_time_core
    import ts_pkg::*;
#(
    parameter int STEP_LOG2 = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [WORD_W-1:0]   alarm,
    output logic [2*WORD_W-1:0] time_q,
    output logic                alarm_hit
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(1) << STEP_LOG2;

    logic [WORD_W:0]   lo_next;
    logic [WORD_W-1:0] gap;

    // Next low word with carry out, and the distance to the alarm.
    always_comb begin
        lo_next   = {1'b0, time_q[WORD_W-1:0]} + {1'b0, STEP};
        gap       = alarm - time_q[WORD_W-1:0];
        alarm_hit = tick && (gap != '0) && (gap <= STEP);
    end

    // Time register: software writes first, otherwise the tick step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) time_q[WORD_W-1:0] <= {wdata[WORD_W-1:STEP_LOG2], STEP_LOG2'(0)};
            if (wr_hi) time_q[2*WORD_W-1:WORD_W] <= wdata;
        end else if (tick) begin
            time_q[WORD_W-1:0]        <= lo_next[WORD_W-1:0];
            time_q[2*WORD_W-1:WORD_W] <= time_q[2*WORD_W-1:WORD_W] + WORD_W'(lo_next[WORD_W]);
        end
    end

    // R3
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        time_q[STEP_LOG2-1:0] == '0);
    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_lo && !wr_hi) |=> time_q == $past(time_q) + 64'(STEP));
    // R5
    still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_lo && !wr_hi) |=> $stable(time_q));
endmodule

// File: rtl/ts_regs.sv
// Register file: the ratio, alarm, enable and status registers, the
// high-word shadow and the combinational read mux.
// Assumes single-cycle strobes and byte offsets defined in ts_pkg.
module ts_regs
    import ts_pkg::*;
#(
    parameter logic [RATIO_W-1:0] RST_DIV = 16'd8,
    parameter logic [RATIO_W-1:0] RST_MUL = 16'd3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [11:0]         addr,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [2*WORD_W-1:0] time_q,
    input  logic                alarm_hit,
    output ratio_cfg_t          cfg,
    output logic [WORD_W-1:0]   alarm_q,
    output logic                wr_lo,
    output logic                wr_hi,
    output logic [WORD_W-1:0]   rdata,
    output logic                irq
);
    logic              ien_q;
    logic              ist_q;
    logic [WORD_W-1:0] shadow_q;
    logic              wr_st;

    // Write decodes that leave this module or feed the status logic.
    always_comb begin
        wr_lo = wr_en && (addr == OFF_TLO);
        wr_hi = wr_en && (addr == OFF_THI);
        wr_st = wr_en && (addr == OFF_ISTAT);
    end

    // Configuration registers, written from the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= '{div: RST_DIV, mul: RST_MUL, src: 2'd0};
            alarm_q <= '0;
            ien_q   <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                OFF_DIV:   cfg.div <= wdata[RATIO_W-1:0];
                OFF_MUL:   cfg.mul <= wdata[RATIO_W-1:0];
                OFF_SRC:   cfg.src <= wdata[1:0];
                OFF_ALARM: alarm_q <= wdata;
                OFF_IEN:   ien_q   <= wdata[0];
                default: ;
            endcase
        end
    end

    // Status bit: the alarm sets it, a write of 1 clears it, and set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)         ist_q <= 1'b0;
        else if (alarm_hit) ist_q <= 1'b1;
        else if (wr_st && wdata[0]) ist_q <= 1'b0;
    end

    // Shadow of the high word, captured by each low-word read.
    always_ff @(posedge clk) begin
        if (!rst_n)                         shadow_q <= '0;
        else if (rd_en && addr == OFF_TLO)  shadow_q <= time_q[2*WORD_W-1:WORD_W];
    end

    // Read mux, zero when not reading or unmapped.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                OFF_ISTAT: rdata = WORD_W'(ist_q);
                OFF_IEN:   rdata = WORD_W'(ien_q);
                OFF_DIV:   rdata = WORD_W'(cfg.div);
                OFF_MUL:   rdata = WORD_W'(cfg.mul);
                OFF_SRC:   rdata = WORD_W'(cfg.src);
                OFF_TLO:   rdata = time_q[WORD_W-1:0];
                OFF_THI:   rdata = shadow_q;
                OFF_ALARM: rdata = alarm_q;
                default:   rdata = '0;
            endcase
        end
    end

    // Interrupt output.
    always_comb irq = ist_q & ien_q;

    // R9
    hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> ist_q);
    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st && wdata[0] && !alarm_hit) |=> !ist_q);
    // R11
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_q |-> !irq);
    // R8
    shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFF_TLO) |=> shadow_q == $past(time_q[2*WORD_W-1:WORD_W]));
endmodule

// File: rtl/ns_timestamp_counter.sv
// Top: nanosecond timestamp counter. Joins the rate generator, time core
// and register file. Assumes one reference clock and a synchronous
// active-low reset.
module ns_timestamp_counter
    import ts_pkg::*;
#(
    parameter int                 STEP_LOG2 = 5,
    parameter logic [RATIO_W-1:0] RST_DIV   = 16'd8,
    parameter logic [RATIO_W-1:0] RST_MUL   = 16'd3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [11:0] addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);
    ratio_cfg_t          cfg;
    logic                tick;
    logic                wr_lo;
    logic                wr_hi;
    logic                alarm_hit;
    logic [WORD_W-1:0]   alarm_q;
    logic [2*WORD_W-1:0] time_q;
    logic                freeze;

    // A time-word write suppresses that cycle's tick.
    always_comb freeze = wr_lo || wr_hi;

    ts_rate_gen u_rate (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .freeze(freeze), .tick(tick)
    );

    ts_time_core #(.STEP_LOG2(STEP_LOG2)) u_time (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wdata(wdata), .alarm(alarm_q), .time_q(time_q), .alarm_hit(alarm_hit)
    );

    ts_regs #(.RST_DIV(RST_DIV), .RST_MUL(RST_MUL)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .time_q(time_q), .alarm_hit(alarm_hit), .cfg(cfg),
        .alarm_q(alarm_q), .wr_lo(wr_lo), .wr_hi(wr_hi), .rdata(rdata), .irq(irq)
    );
endmodule

// File: tb/tb_ns_timestamp_counter.sv
// Bench: behavioural model stepped each clock, compared on reads and irq.
module tb_ns_timestamp_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    string cur_tag = "";

    // model state
    int unsigned     m_acc, m_div, m_mul, m_src;
    longint unsigned m_tm;
    logic [31:0]     m_shadow, m_alarm;
    logic            m_en, m_st;

    ns_timestamp_counter dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        case (a)
            12'h100: return {31'd0, m_st};
            12'h140: return {31'd0, m_en};
            12'h200: return m_div;
            12'h210: return m_mul;
            12'h220: return m_src;
            12'h400: return m_tm[31:0];
            12'h410: return m_shadow;
            12'h420: return m_alarm;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        if (cur_tag != "") return cur_tag;
        case (a)
            12'h100: return "R9";
            12'h140: return "R11";
            12'h200, 12'h210: return "R6";
            12'h220: return "R4";
            12'h400: return "R2";
            12'h410: return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic model_reset();
        m_acc = 0; m_tm = 0; m_div = 8; m_mul = 3; m_src = 0;
        m_shadow = 0; m_alarm = 0; m_en = 0; m_st = 0;
    endtask

    task automatic model_step(input bit w, input bit r, input logic [11:0] a, input logic [31:0] d);
        int unsigned s;
        bit tk, hit, twr;
        logic [31:0] gap;
        tk = 0; hit = 0;
        twr = w && (a == 12'h400 || a == 12'h410);
        if (m_mul != 0 && m_div != 0) begin
            s = m_acc + m_mul * (m_src + 1);
            if (s >= m_div) begin m_acc = s - m_div; tk = !twr; end
            else m_acc = s;
        end
        gap = m_alarm - m_tm[31:0];
        hit = tk && gap != 0 && gap <= 32;
        if (r && a == 12'h400) m_shadow = m_tm[63:32];
        if (tk) m_tm = m_tm + 32;
        if (w) begin
            case (a)
                12'h100: if (d[0]) m_st = 0;
                12'h140: m_en = d[0];
                12'h200: m_div = d[15:0];
                12'h210: m_mul = d[15:0];
                12'h220: m_src = d[1:0];
                12'h400: m_tm = {m_tm[63:32], d[31:5], 5'd0};
                12'h410: m_tm = {d, m_tm[31:0]};
                12'h420: m_alarm = d;
                default: ;
            endcase
        end
        if (hit) m_st = 1;
    endtask

    // One cycle: drive, check read, step at edge, check irq.
    task automatic cyc(input bit w, input bit r, input logic [11:0] a, input logic [31:0] d);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        #1;
        if (r) begin
            chk(tag_of(a), rdata, exp_read(a));
            if (a == 12'h400) chk("R3", {27'd0, rdata[4:0]}, 32'd0);
        end
        @(posedge clk);
        if (rst_n) model_step(w, r, a, d); else model_reset();
        @(negedge clk);
        if (rst_n) chk("R11", {31'd0, irq}, {31'd0, m_en & m_st});
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cyc(1, 0, a, d);
    endtask
    task automatic rd(input logic [11:0] a);
        cyc(0, 1, a, 0);
    endtask
    task automatic watch(input int n);
        for (int i = 0; i < n; i++) rd(12'h400);
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        rst_n = 1'b1;
        // R1 reset state of every register
        cur_tag = "R1";
        rd(12'h100); rd(12'h140); rd(12'h200); rd(12'h210);
        rd(12'h220); rd(12'h400); rd(12'h410); rd(12'h420);
        cur_tag = "R12";
        rd(12'h300); rd(12'h404);
        cur_tag = "";
        // R2 default ratio 3/8
        watch(100);
        // R6 upper bits ignored, ratio 5/8
        wr(12'h210, 32'hABCD_0005); wr(12'h200, 32'hFFFF_0008);
        rd(12'h210); rd(12'h200);
        watch(60);
        // R4 source factor x4 with 1/4 -> ratio one
        wr(12'h220, 32'd3); wr(12'h210, 32'd1); wr(12'h200, 32'd4);
        rd(12'h220);
        watch(20);
        // R4 factor x2, 3/7 -> 6/7
        wr(12'h220, 32'd1); wr(12'h210, 32'd3); wr(12'h200, 32'd7);
        watch(30);
        // R5 zero multiplier, then zero divisor
        cur_tag = "R5";
        wr(12'h210, 32'd0); watch(20);
        wr(12'h210, 32'd3); wr(12'h200, 32'd0); watch(20);
        cur_tag = "";
        wr(12'h200, 32'd7); watch(10);
        // R7 time writes, forced low bits
        cur_tag = "R7";
        wr(12'h220, 32'd0); wr(12'h210, 32'd1); wr(12'h200, 32'd1);
        wr(12'h410, 32'd5); wr(12'h400, 32'hFFFF_FFC7);
        rd(12'h400);
        cur_tag = "";
        // R8 shadow holds 5 after the low read while high becomes 6
        rd(12'h410); rd(12'h410);
        rd(12'h400); rd(12'h410);
        cur_tag = "R8";
        rd(12'h400); rd(12'h410);
        cur_tag = "";
        // R9 alarm crossing with enable, then R10 clear, R11 mask
        wr(12'h140, 32'd1); wr(12'h420, 32'h100); wr(12'h400, 32'hC0);
        watch(6);
        rd(12'h100);
        cur_tag = "R10";
        wr(12'h100, 32'hFFFF_FFFF); rd(12'h100);
        cur_tag = "R9";
        wr(12'h420, 32'h0); wr(12'h400, 32'hFFFF_FFC0);
        watch(4); rd(12'h100);
        cur_tag = "R11";
        wr(12'h140, 32'd0); rd(12'h140); rd(12'h100);
        cur_tag = "R10";
        wr(12'h100, 32'hFFFF_FFFF); rd(12'h100);
        cur_tag = "";
        // R2 slow fractional ratio with x3 factor
        wr(12'h220, 32'd2); wr(12'h210, 32'd250); wr(12'h200, 32'd800);
        watch(80);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule